// File: doc/BRIEF.md
# Cache tag directory with valid-qualified match

This block is the tag directory of a secondary cache. Each entry is selected by a cache index and holds an address tag and three status bits: valid, dirty and write-through. The tag presented with the index is compared against the stored tag without any clock. The hit flag that results is raised only for a valid entry. The block also produces a burst-ready indication for the cache controller, built from the hit, the write-through bit and an external qualifier.

Writes to the tag field and to the status field each have their own enable and take effect on the rising clock edge. An active-low invalidate input, sampled at the edge, clears the status of every entry in one cycle. Two chip selects, which must both be high, let several directories be combined for depth. A power-down input idles the block. A mode input chooses between two meanings for the status bits. In internal mode the block maintains them itself. In user mode they are plain storage.

Top module: `ctag_dir`

## Requirements
- R1: `hit` is high exactly when the block is active, the stored tag at `idx` equals `cmp_tag`, and the stored valid bit is set. It follows `idx` and `cmp_tag` combinationally. Status encoding: bit 0 is valid, bit 1 is dirty, bit 2 is write-through.
- R2: An entry whose valid bit is clear never produces `hit`, whatever tag it holds.
- R3: `tag_rdata` and `st_rdata` show the entry at `idx` combinationally while their enables are high. `tag_rdata_en` is `tag_oe` AND active, and `st_rdata_en` is `st_oe` AND active. A data output whose enable is low reads zero.
- R4: With the block active and `tag_we` high, the entry's tag takes `tag_wdata` at the rising edge. The tag is not changed by any status write.
- R5: With the block active and `st_we` high, all three status bits of the entry take `st_wdata` at the rising edge, in either mode. The stored tag is left unchanged.
- R6: `inv_n` low at a rising edge clears every status bit of every entry, whatever the selects or power-down. It overrides all status updates in that cycle. A tag write in the same cycle still lands.
- R7: When `user_mode` is 0, a tag write without `st_we` sets valid, clears dirty and keeps write-through. If `st_we` is also high, the status write wins.
- R8: When `user_mode` is 0, a write hit sets dirty. A write hit is an active cycle with `bus_wr` high, `hit` high, write-through clear and neither write enable. When `user_mode` is 1, a write hit leaves the status unchanged.
- R9: `burst_rdy_en` is `rdy_oe` AND active. `burst_rdy` is high when `burst_rdy_en`, `rdy_en` and `hit` are all high and either `bus_wr` is low or write-through is clear.
- R10: The block is active when `sel_a` and `sel_b` are both high and `pwr_down` is low. While it is not active, tag writes, status writes and dirty updates are ignored, `hit` is low and every output enable is low.
- R11: When `user_mode` is 1, a tag write leaves all three status bits of the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| inv_n | input | 1 | Synchronous invalidate of all status, active low |
| sel_a | input | 1 | Chip select A, active high |
| sel_b | input | 1 | Chip select B, active high |
| pwr_down | input | 1 | Power-down, idles the block |
| user_mode | input | 1 | 1 = status bits are user storage, 0 = maintained internally |
| idx | input | IDX_W | Entry index |
| cmp_tag | input | TAG_W | Tag compared against the stored tag |
| tag_wdata | input | TAG_W | Tag write data |
| tag_we | input | 1 | Tag write enable |
| st_wdata | input | 3 | Status write data {wt, dirty, valid} |
| st_we | input | 1 | Status write enable |
| bus_wr | input | 1 | Current cache access is a write |
| rdy_en | input | 1 | External burst-ready qualifier |
| tag_oe | input | 1 | Tag read output enable |
| st_oe | input | 1 | Status read output enable |
| rdy_oe | input | 1 | Burst-ready output enable |
| hit | output | 1 | Valid-qualified tag match |
| tag_rdata | output | TAG_W | Stored tag at `idx` |
| tag_rdata_en | output | 1 | Drive enable for `tag_rdata` |
| st_rdata | output | 3 | Stored status at `idx` |
| st_rdata_en | output | 1 | Drive enable for `st_rdata` |
| burst_rdy | output | 1 | Burst-ready indication |
| burst_rdy_en | output | 1 | Drive enable for `burst_rdy` |

## Verification
The assertions assume that `idx` and the write inputs are steady around each rising edge, and that `inv_n` is the only source of reset. The stimulus changes every input only at the falling edge. Before any checking it pulses `inv_n` low. It then writes every tag entry once in user mode, so that no hit can depend on a tag that was never written. In the random phase the bench mostly presents the tag already stored at a small set of indices, so that hits, write hits and dirty updates happen often.

// File: rtl/ctag_pkg.sv
`timescale 1ns/1ps
package ctag_pkg;
  localparam int ST_W = 3;

  typedef struct packed {
    logic wt;
    logic dty;
    logic vld;
  } ctag_st_t;
endpackage

// File: rtl/ctag_tag_ram.sv
`timescale 1ns/1ps
module ctag_tag_ram #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] addr,
  input  logic [TAG_W-1:0] wdata,
  output logic [TAG_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  p_tag_wr_r4: assert property (@(posedge clk)
    we |=> (addr != $past(addr)) || (rdata == $past(wdata)));
endmodule

// File: rtl/ctag_status.sv
`timescale 1ns/1ps
module ctag_status
  import ctag_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             inv_n,
  input  logic             wr_ok,
  input  logic             user_mode,
  input  logic [IDX_W-1:0] idx,
  input  logic             tag_we,
  input  logic             st_we,
  input  ctag_st_t         st_wdata,
  input  logic             bus_wr,
  input  logic             hit,
  output ctag_st_t         rd
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld, dty, wt;

  logic auto_fill, wr_hit;
  assign auto_fill = !user_mode && tag_we && !st_we;
  assign wr_hit    = !user_mode && bus_wr && hit && !wt[idx] && !tag_we && !st_we;

  always_ff @(posedge clk) begin
    if (!inv_n) begin
      vld <= '0;
      dty <= '0;
      wt  <= '0;
    end else if (wr_ok) begin
      if (st_we) begin
        vld[idx] <= st_wdata.vld;
        dty[idx] <= st_wdata.dty;
        wt[idx]  <= st_wdata.wt;
      end else if (auto_fill) begin
        vld[idx] <= 1'b1;
        dty[idx] <= 1'b0;
      end else if (wr_hit) begin
        dty[idx] <= 1'b1;
      end
    end
  end

  assign rd.vld = vld[idx];
  assign rd.dty = dty[idx];
  assign rd.wt  = wt[idx];

  p_inval_clears_r6: assert property (@(posedge clk)
    !inv_n |=> (vld == '0) && (dty == '0) && (wt == '0));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!inv_n)
    !wr_ok |=> $stable(vld) && $stable(dty) && $stable(wt));

  p_fill_valid_r7: assert property (@(posedge clk) disable iff (!inv_n)
    (wr_ok && !user_mode && tag_we && !st_we) |=> vld[$past(idx)] && !dty[$past(idx)]);

  p_wrhit_dirty_r8: assert property (@(posedge clk) disable iff (!inv_n)
    (wr_ok && !user_mode && bus_wr && hit && !rd.wt && !tag_we && !st_we) |=> dty[$past(idx)]);
endmodule

// File: rtl/ctag_ready.sv
`timescale 1ns/1ps
module ctag_ready (
  input  logic active,
  input  logic rdy_oe,
  input  logic rdy_en,
  input  logic hit,
  input  logic bus_wr,
  input  logic wt,
  output logic burst_rdy,
  output logic burst_rdy_en
);
  logic hit_ok;

  always_comb begin
    hit_ok       = hit && (!bus_wr || !wt);
    burst_rdy_en = active && rdy_oe;
    burst_rdy    = burst_rdy_en && rdy_en && hit_ok;
  end
endmodule

// File: rtl/ctag_dir.sv
`timescale 1ns/1ps
module ctag_dir
  import ctag_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             inv_n,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             pwr_down,
  input  logic             user_mode,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic [TAG_W-1:0] tag_wdata,
  input  logic             tag_we,
  input  logic [ST_W-1:0]  st_wdata,
  input  logic             st_we,
  input  logic             bus_wr,
  input  logic             rdy_en,
  input  logic             tag_oe,
  input  logic             st_oe,
  input  logic             rdy_oe,
  output logic             hit,
  output logic [TAG_W-1:0] tag_rdata,
  output logic             tag_rdata_en,
  output logic [ST_W-1:0]  st_rdata,
  output logic             st_rdata_en,
  output logic             burst_rdy,
  output logic             burst_rdy_en
);
  logic             active;
  logic [TAG_W-1:0] tag_rd;
  ctag_st_t         st_rd;

  assign active = sel_a && sel_b && !pwr_down;

  ctag_tag_ram #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk   (clk),
    .we    (active && tag_we),
    .addr  (idx),
    .wdata (tag_wdata),
    .rdata (tag_rd)
  );

  ctag_status #(.IDX_W(IDX_W)) u_stat (
    .clk       (clk),
    .inv_n     (inv_n),
    .wr_ok     (active),
    .user_mode (user_mode),
    .idx       (idx),
    .tag_we    (tag_we),
    .st_we     (st_we),
    .st_wdata  (ctag_st_t'(st_wdata)),
    .bus_wr    (bus_wr),
    .hit       (hit),
    .rd        (st_rd)
  );

  assign hit = active && st_rd.vld && (tag_rd == cmp_tag);

  assign tag_rdata_en = active && tag_oe;
  assign st_rdata_en  = active && st_oe;
  assign tag_rdata    = tag_rdata_en ? tag_rd : '0;
  assign st_rdata     = st_rdata_en ? ST_W'(st_rd) : '0;

  ctag_ready u_rdy (
    .active       (active),
    .rdy_oe       (rdy_oe),
    .rdy_en       (rdy_en),
    .hit          (hit),
    .bus_wr       (bus_wr),
    .wt           (st_rd.wt),
    .burst_rdy    (burst_rdy),
    .burst_rdy_en (burst_rdy_en)
  );

  p_hit_valid_r2: assert property (@(posedge clk) disable iff (!inv_n)
    hit |-> st_rd.vld);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!inv_n)
    !active |-> !hit && !burst_rdy && !tag_rdata_en && !st_rdata_en && !burst_rdy_en);

  p_rdy_hit_r9: assert property (@(posedge clk) disable iff (!inv_n)
    burst_rdy |-> hit && rdy_en);
endmodule

// File: tb/sim_ctag_dir.sv
`timescale 1ns/1ps
module sim_ctag_dir;
  localparam int IDX_W = 8;
  localparam int TAG_W = 12;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic inv_n, sel_a, sel_b, pwr_down, user_mode;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] cmp_tag, tag_wdata;
  logic tag_we, st_we, bus_wr, rdy_en, tag_oe, st_oe, rdy_oe;
  logic [2:0] st_wdata;
  logic hit, tag_rdata_en, st_rdata_en, burst_rdy, burst_rdy_en;
  logic [TAG_W-1:0] tag_rdata;
  logic [2:0] st_rdata;

  ctag_dir #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u0 (
    .clk(clk), .inv_n(inv_n), .sel_a(sel_a), .sel_b(sel_b), .pwr_down(pwr_down),
    .user_mode(user_mode), .idx(idx), .cmp_tag(cmp_tag), .tag_wdata(tag_wdata),
    .tag_we(tag_we), .st_wdata(st_wdata), .st_we(st_we), .bus_wr(bus_wr),
    .rdy_en(rdy_en), .tag_oe(tag_oe), .st_oe(st_oe), .rdy_oe(rdy_oe),
    .hit(hit), .tag_rdata(tag_rdata), .tag_rdata_en(tag_rdata_en),
    .st_rdata(st_rdata), .st_rdata_en(st_rdata_en),
    .burst_rdy(burst_rdy), .burst_rdy_en(burst_rdy_en)
  );

  // reference state
  int m_tag [DEPTH];
  bit m_v [DEPTH];
  bit m_d [DEPTH];
  bit m_w [DEPTH];
  bit checking = 0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_act();
    return sel_a && sel_b && !pwr_down;
  endfunction

  function automatic bit exp_hit();
    int i = int'(idx);
    return is_act() && m_v[i] && (m_tag[i] == int'(cmp_tag));
  endfunction

  task automatic compare();
    int  i  = int'(idx);
    bit  a  = is_act();
    bit  eh = exp_hit();
    bit  er;
    chk("R1 R2 hit", int'(hit), int'(eh));
    chk("R3 R10 tag_rdata_en", int'(tag_rdata_en), int'(a && tag_oe));
    chk("R3 R10 st_rdata_en", int'(st_rdata_en), int'(a && st_oe));
    chk("R3 R4 tag_rdata", int'(tag_rdata), (a && tag_oe) ? m_tag[i] : 0);
    chk("R3 R5 st_rdata", int'(st_rdata),
        (a && st_oe) ? int'({m_w[i], m_d[i], m_v[i]}) : 0);
    chk("R9 R10 burst_rdy_en", int'(burst_rdy_en), int'(a && rdy_oe));
    er = a && rdy_oe && rdy_en && eh && (!bus_wr || !m_w[i]);
    chk("R9 burst_rdy", int'(burst_rdy), int'(er));
  endtask

  task automatic model_edge();
    int i  = int'(idx);
    bit eh = exp_hit();
    if (is_act() && tag_we) m_tag[i] = int'(tag_wdata);
    if (!inv_n) begin
      for (int k = 0; k < DEPTH; k++) begin m_v[k] = 0; m_d[k] = 0; m_w[k] = 0; end
    end else if (is_act()) begin
      if (st_we) begin
        m_v[i] = st_wdata[0]; m_d[i] = st_wdata[1]; m_w[i] = st_wdata[2];
      end else if (!user_mode && tag_we) begin
        m_v[i] = 1; m_d[i] = 0;
      end else if (!user_mode && bus_wr && eh && !m_w[i]) begin
        m_d[i] = 1;
      end
    end
  endtask

  // inputs are held steady from a falling edge to the next falling edge
  task automatic tick();
    #1;
    if (checking) compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    inv_n = 1; sel_a = 1; sel_b = 1; pwr_down = 0;
    tag_we = 0; st_we = 0; bus_wr = 0; rdy_en = 1;
    tag_oe = 1; st_oe = 1; rdy_oe = 1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(); user_mode = 1; idx = '0; cmp_tag = '0; tag_wdata = '0; st_wdata = '0;
    inv_n = 0;
    @(negedge clk);
    tick(); tick();
    checking = 1;
    inv_n = 1;
    // R6 reset state: every status bit reads zero, nothing hits
    for (int k = 0; k < 4; k++) begin idx = IDX_W'(k * 37); tick(); end

    // R11: fill every tag in user mode, status stays clear
    tag_we = 1;
    for (int k = 0; k < DEPTH; k++) begin
      idx = IDX_W'(k); tag_wdata = TAG_W'(k * 13 + 5); cmp_tag = tag_wdata; tick();
    end
    tag_we = 0;
    idx = 8'd3; cmp_tag = TAG_W'(3 * 13 + 5); tick(); // R2 tag equal but invalid
    chk("R2 invalid entry no hit", int'(hit), 0);

    // R7 internal-mode fill marks valid, then R1 hit
    user_mode = 0; tag_we = 1; tag_wdata = 12'hABC; cmp_tag = 12'hABC; tick();
    tag_we = 0; tick();
    chk("R7 fill sets valid", int'(st_rdata), 1);
    chk("R1 hit after fill", int'(hit), 1);
    // R8 write hit sets dirty
    bus_wr = 1; tick(); bus_wr = 0; tick();
    chk("R8 write hit dirty", int'(st_rdata), 3);
    // R5 status write leaves tag alone, write-through then blocks write ready (R9)
    st_we = 1; st_wdata = 3'b101; tick(); st_we = 0; bus_wr = 1; tick();
    chk("R9 no ready on wt write hit", int'(burst_rdy), 0);
    chk("R5 tag kept", int'(tag_rdata), 12'hABC);
    bus_wr = 0; tick();
    chk("R9 ready on read hit", int'(burst_rdy), 1);
    // R10 deselected: writes ignored, all quiet
    sel_b = 0; tag_we = 1; tag_wdata = 12'h111; st_we = 1; st_wdata = 3'b010; tick();
    chk("R10 no hit deselected", int'(hit), 0);
    tag_we = 0; st_we = 0; sel_b = 1; tick();
    chk("R10 tag unchanged", int'(tag_rdata), 12'hABC);
    pwr_down = 1; tick(); pwr_down = 0;
    // R6 invalidate while deselected still clears
    sel_a = 0; inv_n = 0; tick(); inv_n = 1; sel_a = 1; tick();
    chk("R6 invalidated", int'(st_rdata), 0);
    // R11 user mode tag write leaves status
    user_mode = 1; st_we = 1; st_wdata = 3'b110; tick(); st_we = 0;
    tag_we = 1; tag_wdata = 12'h5A5; tick(); tag_we = 0; tick();
    chk("R11 status kept", int'(st_rdata), 6);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int i;
      idle();
      i = int'($urandom_range(0, 7));
      idx = IDX_W'(i);
      user_mode = ($urandom_range(0, 3) == 0);
      sel_a = ($urandom_range(0, 7) != 0);
      sel_b = ($urandom_range(0, 7) != 0);
      pwr_down = ($urandom_range(0, 15) == 0);
      inv_n = ($urandom_range(0, 63) != 0);
      tag_we = ($urandom_range(0, 5) == 0);
      st_we = ($urandom_range(0, 5) == 0);
      st_wdata = 3'($urandom);
      tag_wdata = TAG_W'($urandom);
      bus_wr = $urandom_range(0, 1);
      rdy_en = ($urandom_range(0, 3) != 0);
      tag_oe = ($urandom_range(0, 3) != 0);
      st_oe = ($urandom_range(0, 3) != 0);
      rdy_oe = ($urandom_range(0, 3) != 0);
      cmp_tag = ($urandom_range(0, 3) != 0) ? TAG_W'(m_tag[i]) : TAG_W'($urandom);
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule